// File: doc/BRIEF.md
# Cascaded-Counter Time-Stamp Capture with Rollover Repair

This block measures the time between input edges with 16-bit precision, using a counter built from two 8-bit halves. A prescaled tick advances the low half. The low half's wrap from all-ones to zero advances the high half. When a qualified edge arrives, only the low half is frozen in hardware.

The matching high half is recovered afterwards by a read sequencer. The sequencer takes the live high half, then the live low half, then the live high half again. It then decides whether the low half wrapped after the edge, and picks the right high value. The reads are spaced by a programmable number of clock cycles.

Two capture lanes share one input. One lane takes rising edges and the other takes falling edges, which gives pulse width. In period mode only the rising lane is used, and a toggling flag sends alternate captures to the start and end stamps, which gives the rise-to-rise period.

Top module: `cascade_stamp_capture`

## Requirements
- R1: After reset, `start_stamp`, `end_stamp` and `span` are 0, and `result_valid` and `overrun` are 0.
- R2: The 16-bit count starts at 0 at reset release and advances by one on each prescaler tick. The high byte advances only on the tick that takes the low byte from FFh to 00h. The count wraps modulo 2^16.
- R3: A qualified edge freezes the low byte of the count as it stood in the clock cycle when the edge was sampled. The low byte of the reported stamp equals that frozen value. `sig_in` is sampled on each clock edge, so an edge is one sample that differs from the sample before it.
- R4: The high byte of a stamp is rebuilt from three reads taken in order: high (H1), low (L), high (H2). The high byte is H1 when L is greater than or equal to the frozen low byte, and H2 minus 1 otherwise. The rebuilt stamp therefore equals the full count at the edge, even when the low byte wraps before the reads.
- R5: With `period_mode`=0, a rising edge writes `start_stamp` and a falling edge writes `end_stamp`. `span` = `end_stamp` − `start_stamp`, taken modulo 2^16.
- R6: With `period_mode`=1, falling edges are ignored. Rising edges go alternately to `start_stamp` and then to `end_stamp`, the first after reset going to the start. `span` is computed after each end capture, and the routing then returns to the start stamp.
- R7: An edge on a lane whose previous capture has not yet been consumed by the sequencer overwrites that lane's frozen byte. It also sets `overrun`, which stays at 1 until reset.
- R8: After reading H1, the sequencer waits `read_gap`+1 cycles and reads L. It then waits `read_gap`+1 cycles more and reads H2. Any one capture is handled as exactly that sequence.
- R9: `result_valid` is high for exactly one clock cycle, in the first cycle that shows a new `end_stamp` and `span`. It is never raised for a start capture.
- R10: `div_sel` code k (0 to 7) makes the count advance once every 2^k clock cycles, counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Measured signal, synchronous to clk |
| div_sel | input | 3 | Prescaler code k; divide by 2^k |
| period_mode | input | 1 | 0 = pulse width, 1 = rise-to-rise period |
| read_gap | input | 4 | Extra wait cycles between sequencer reads |
| start_stamp | output | 16 | Stamp of the start edge |
| end_stamp | output | 16 | Stamp of the end edge |
| span | output | 16 | end_stamp minus start_stamp, modulo 2^16 |
| result_valid | output | 1 | One-cycle strobe for a new end stamp and span |
| overrun | output | 1 | Sticky: a capture was overwritten before use |

## Verification
A wrong wrap decision in the sequencer does not show as a small error. It shows as a stamp that is off by exactly 256 ticks, and that error reaches the ports at the very next `result_valid`. The bench places edges a few ticks before a low-byte wrap and uses long read gaps, so that the H2−1 branch is taken.

A prescaler or cascade fault shifts every stamp away from the value the bench predicts from its own cycle count. A fault in the first-edge flag or in lane arming shows as a wrong stamp, or as a strobe that is missing or extra within one measurement. A lost overrun shows as `overrun` still at 0 a few cycles after a back-to-back edge.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int LOW_W   = 8;
  localparam int HIGH_W  = 8;
  localparam int STAMP_W = LOW_W + HIGH_W;

  localparam logic [LOW_W-1:0]  LO_ONE = 1;
  localparam logic [HIGH_W-1:0] HI_ONE = 1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_H1,
    SQ_WAIT1,
    SQ_RD_L,
    SQ_WAIT2,
    SQ_RD_H2,
    SQ_FINISH
  } seq_state_t;

  // Pick the high byte that belonged to the frozen low byte.
  function automatic logic [HIGH_W-1:0] mend_high(
    input logic [HIGH_W-1:0] h_first,
    input logic [LOW_W-1:0]  l_live,
    input logic [LOW_W-1:0]  l_frozen,
    input logic [HIGH_W-1:0] h_second
  );
    if (l_live >= l_frozen) return h_first;
    return h_second - HI_ONE;
  endfunction

  function automatic logic [STAMP_W-1:0] elapsed(
    input logic [STAMP_W-1:0] from_stamp,
    input logic [STAMP_W-1:0] to_stamp
  );
    return to_stamp - from_stamp;
  endfunction
endpackage

// File: rtl/stamp_prescaler.sv
module stamp_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (2 ** SEL_W) - 1;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    low_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(div_sel)) low_mask[i] = 1'b1;
    end
  end

  assign tick = &(pre_q | ~low_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_ONE;
  end

  AST_TICK_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0) |-> tick);                                   // R10
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0 && $stable(div_sel)) |=> !tick);      // R10
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import stamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output logic [LOW_W-1:0]  lo_q,
  output logic [HIGH_W-1:0] hi_q,
  output logic              carry
);
  assign carry = tick & (&lo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (tick)  lo_q <= lo_q + LO_ONE;
      if (carry) hi_q <= hi_q + HI_ONE;
    end
  end

  AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (lo_q == $past(lo_q) + LO_ONE));                    // R2
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !carry |=> $stable(hi_q));                                   // R2
  AST_HI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (hi_q == $past(hi_q) + HI_ONE && lo_q == '0));     // R2
endmodule

// File: rtl/capture_lane.sv
module capture_lane
  import stamp_pkg::*;
#(
  parameter bit RISE_SENSE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_now,
  input  logic             sig_prev,
  input  logic             arm,
  input  logic [LOW_W-1:0] lo_now,
  input  logic             consume,
  output logic [LOW_W-1:0] lat_q,
  output logic             pending_q,
  output logic             ovr_q,
  output logic             hit
);
  logic edge_seen;
  assign edge_seen = RISE_SENSE ? (sig_now & ~sig_prev) : (~sig_now & sig_prev);
  assign hit = arm & edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= '0;
      pending_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else if (hit) begin
      lat_q     <= lo_now;
      pending_q <= 1'b1;
      if (pending_q) ovr_q <= 1'b1;
    end else if (consume) begin
      pending_q <= 1'b0;
    end
  end

  AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (lat_q == $past(lo_now) && pending_q));              // R3
  AST_OVR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pending_q) |=> ovr_q);                               // R7
  AST_NO_LATE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(lat_q));                                    // R3
endmodule

// File: rtl/rebuild_sequencer.sv
module rebuild_sequencer
  import stamp_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               period_mode,
  input  logic [GAP_W-1:0]   gap,
  input  logic [LOW_W-1:0]   lo_now,
  input  logic [HIGH_W-1:0]  hi_now,
  input  logic [1:0]         pend,
  input  logic [LOW_W-1:0]   lat_rise,
  input  logic [LOW_W-1:0]   lat_fall,
  output logic [1:0]         consume,
  output logic [STAMP_W-1:0] start_q,
  output logic [STAMP_W-1:0] end_q,
  output logic [STAMP_W-1:0] span_q,
  output logic               valid_q
);
  localparam logic [GAP_W-1:0] GAP_ONE = 1;

  seq_state_t          state_q;
  logic                sel_q;
  logic                first_q;
  logic [HIGH_W-1:0]   h1_q, h2_q;
  logic [LOW_W-1:0]    lm_q;
  logic [GAP_W-1:0]    gcnt_q;
  logic [LOW_W-1:0]    lat_sel;
  logic [STAMP_W-1:0]  stamp_w;
  logic                finish_evt;

  assign lat_sel    = sel_q ? lat_fall : lat_rise;
  assign stamp_w    = {mend_high(h1_q, lm_q, lat_sel, h2_q), lat_sel};
  assign finish_evt = (state_q == SQ_FINISH);

  always_comb begin
    consume = '0;
    if (finish_evt) consume[sel_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      sel_q   <= 1'b0;
      first_q <= 1'b0;
      h1_q    <= '0;
      h2_q    <= '0;
      lm_q    <= '0;
      gcnt_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      span_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (pend[0]) begin
            sel_q   <= 1'b0;
            state_q <= SQ_RD_H1;
          end else if (pend[1]) begin
            sel_q   <= 1'b1;
            state_q <= SQ_RD_H1;
          end
        end
        SQ_RD_H1: begin
          h1_q    <= hi_now;
          gcnt_q  <= gap;
          state_q <= SQ_WAIT1;
        end
        SQ_WAIT1: begin
          if (gcnt_q == '0) state_q <= SQ_RD_L;
          else              gcnt_q  <= gcnt_q - GAP_ONE;
        end
        SQ_RD_L: begin
          lm_q    <= lo_now;
          gcnt_q  <= gap;
          state_q <= SQ_WAIT2;
        end
        SQ_WAIT2: begin
          if (gcnt_q == '0) state_q <= SQ_RD_H2;
          else              gcnt_q  <= gcnt_q - GAP_ONE;
        end
        SQ_RD_H2: begin
          h2_q    <= hi_now;
          state_q <= SQ_FINISH;
        end
        SQ_FINISH: begin
          state_q <= SQ_IDLE;
          if (period_mode) begin
            if (!first_q) begin
              start_q <= stamp_w;
              first_q <= 1'b1;
            end else begin
              end_q   <= stamp_w;
              span_q  <= elapsed(start_q, stamp_w);
              valid_q <= 1'b1;
              first_q <= 1'b0;
            end
          end else if (!sel_q) begin
            start_q <= stamp_w;
          end else begin
            end_q   <= stamp_w;
            span_q  <= elapsed(start_q, stamp_w);
            valid_q <= 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);                                       // R9
  AST_SPAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (span_q == end_q - start_q));                    // R5
  AST_L_AFTER_H1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RD_L) |-> ($past(state_q) == SQ_WAIT1));      // R8
  AST_H2_AFTER_L: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RD_H2) |-> ($past(state_q) == SQ_WAIT2));     // R8
  AST_CONSUME_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (consume != '0) |-> pend[sel_q]);                            // R7
endmodule

// File: rtl/cascade_stamp_capture.sv
module cascade_stamp_capture
  import stamp_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int GAP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_in,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               period_mode,
  input  logic [GAP_W-1:0]   read_gap,
  output logic [STAMP_W-1:0] start_stamp,
  output logic [STAMP_W-1:0] end_stamp,
  output logic [STAMP_W-1:0] span,
  output logic               result_valid,
  output logic               overrun
);
  localparam int LANES = 2;

  logic              tick;
  logic              carry;
  logic [LOW_W-1:0]  lo_cnt;
  logic [HIGH_W-1:0] hi_cnt;
  logic              sig_q;
  logic [LANES-1:0]  lane_arm, pend_v, ovr_v, hit_v, consume_v;
  logic [LOW_W-1:0]  lat_v [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  stamp_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
  );

  cascade_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lo_q(lo_cnt), .hi_q(hi_cnt), .carry(carry)
  );

  assign lane_arm = {~period_mode, 1'b1};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    capture_lane #(.RISE_SENSE(g == 0)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .sig_now(sig_in), .sig_prev(sig_q),
      .arm(lane_arm[g]), .lo_now(lo_cnt), .consume(consume_v[g]),
      .lat_q(lat_v[g]), .pending_q(pend_v[g]), .ovr_q(ovr_v[g]), .hit(hit_v[g])
    );
  end

  rebuild_sequencer #(.GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .period_mode(period_mode), .gap(read_gap),
    .lo_now(lo_cnt), .hi_now(hi_cnt), .pend(pend_v),
    .lat_rise(lat_v[0]), .lat_fall(lat_v[1]),
    .consume(consume_v), .start_q(start_stamp), .end_q(end_stamp),
    .span_q(span), .valid_q(result_valid)
  );

  assign overrun = |ovr_v;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);                                        // R7
  AST_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (period_mode && $stable(period_mode)) |=> !pend_v[1]);       // R6
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (lo_cnt == '0));                                   // R2
endmodule

// File: tb/tb_cascade_stamp_capture.sv
`timescale 1ns/1ps
module tb_cascade_stamp_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic        period_mode = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [3:0]  read_gap = 4'd0;
  logic [15:0] start_stamp, end_stamp, span;
  logic        result_valid, overrun;

  cascade_stamp_capture dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .div_sel(div_sel),
    .period_mode(period_mode), .read_gap(read_gap),
    .start_stamp(start_stamp), .end_stamp(end_stamp), .span(span),
    .result_valid(result_valid), .overrun(overrun)
  );

  always #4 clk = ~clk;

  int cyc;
  int n_valid;
  int n_cmp = 0;
  int n_bad = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc     <= 0;
      n_valid <= 0;
    end else begin
      cyc <= cyc + 1;
      if (result_valid) n_valid <= n_valid + 1;
    end
  end

  typedef struct packed {
    logic        pm;
    logic [2:0]  dv;
    logic [3:0]  gp;
    logic [31:0] t;
    logic [31:0] w;
    logic [15:0] span;
  } vec_t;

  // mode, divider code, read gap, first edge cycle, width/period, expected span
  localparam vec_t VT [8] = '{
    '{1'b0, 3'd0, 4'd0,  32'd100,  32'd50,   16'd50},
    '{1'b0, 3'd0, 4'd8,  32'd254,  32'd3,    16'd3},
    '{1'b0, 3'd0, 4'd15, 32'd760,  32'd272,  16'd272},
    '{1'b0, 3'd2, 4'd3,  32'd400,  32'd1200, 16'd300},
    '{1'b0, 3'd7, 4'd1,  32'd1280, 32'd2560, 16'd20},
    '{1'b1, 3'd0, 4'd5,  32'd300,  32'd700,  16'd700},
    '{1'b1, 3'd1, 4'd12, 32'd1020, 32'd1000, 16'd500},
    '{1'b0, 3'd0, 4'd15, 32'd509,  32'd2,    16'd2}
  };

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] stamp_at(input int t, input logic [2:0] dv);
    logic [31:0] x;
    x = t >> dv;
    return x[15:0];
  endfunction

  task automatic restart(input logic pm, input logic [2:0] dv, input logic [3:0] gp);
    @(negedge clk);
    rst_n       = 1'b0;
    sig_in      = 1'b0;
    period_mode = pm;
    div_sel     = dv;
    read_gap    = gp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_valid(input string what);
    int k;
    k = 0;
    while (!result_valid && k < 400) begin
      @(negedge clk);
      k++;
    end
    n_cmp++;
    if (!result_valid) begin
      n_bad++;
      $display("FAIL %s result_valid actual=0 expected=1", what);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    int nv;
    logic [15:0] s_exp, e_exp;

    // R1: reset state
    restart(1'b0, 3'd0, 4'd0);
    @(negedge clk);
    chk("R1 start_stamp", start_stamp, 16'h0000);
    chk("R1 end_stamp", end_stamp, 16'h0000);
    chk("R1 span", span, 16'h0000);
    chk("R1 result_valid", {15'd0, result_valid}, 16'h0000);
    chk("R1 overrun", {15'd0, overrun}, 16'h0000);

    // Vector table: R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VT[i];
      restart(v.pm, v.dv, v.gp);
      s_exp = stamp_at(int'(v.t), v.dv);
      e_exp = stamp_at(int'(v.t + v.w), v.dv);
      wait_to(int'(v.t));
      sig_in = 1'b1;
      if (v.pm) begin
        wait_to(int'(v.t) + 2);
        sig_in = 1'b0;
        wait_to(int'(v.t + v.w));
        sig_in = 1'b1;
        wait_to(int'(v.t + v.w) + 2);
        sig_in = 1'b0;
      end else begin
        wait_to(int'(v.t + v.w));
        sig_in = 1'b0;
      end
      wait_valid($sformatf("R9 vec%0d", i));
      chk($sformatf("R3/R4/R10 vec%0d start_stamp", i), start_stamp, s_exp);
      chk($sformatf("R2/R4/R8 vec%0d end_stamp", i), end_stamp, e_exp);
      chk($sformatf("R5/R6 vec%0d span", i), span, v.span);
      chk($sformatf("R7 vec%0d overrun", i), {15'd0, overrun}, 16'h0000);
      @(negedge clk);
      chk($sformatf("R9 vec%0d strobe width", i), {15'd0, result_valid}, 16'h0000);
    end

    // R5 / R2: span across the 16-bit wrap, high byte FFh -> 00h
    restart(1'b0, 3'd0, 4'd2);
    wait_to(65528);
    sig_in = 1'b1;
    wait_to(65552);
    sig_in = 1'b0;
    wait_valid("R5 wrap");
    chk("R4 wrap start_stamp", start_stamp, 16'hFFF8);
    chk("R2 wrap end_stamp", end_stamp, 16'h0010);
    chk("R5 wrap span", span, 16'h0018);

    // R6: routing returns to start after an end capture
    restart(1'b1, 3'd0, 4'd0);
    wait_to(200); sig_in = 1'b1;
    wait_to(202); sig_in = 1'b0;
    wait_to(500); sig_in = 1'b1;
    wait_to(502); sig_in = 1'b0;
    wait_valid("R6 toggle");
    chk("R6 toggle end_stamp", end_stamp, 16'd500);
    @(negedge clk);
    nv = n_valid;
    wait_to(900); sig_in = 1'b1;
    wait_to(902); sig_in = 1'b0;
    wait_to(980);
    chk("R6 third rise start_stamp", start_stamp, 16'd900);
    chk("R6 third rise end_stamp kept", end_stamp, 16'd500);
    chk("R9 no strobe on start capture", 16'(n_valid - nv), 16'd0);

    // R7: second rising edge while first capture is still pending
    restart(1'b1, 3'd0, 4'd15);
    wait_to(100); sig_in = 1'b1;
    wait_to(102); sig_in = 1'b0;
    wait_to(104); sig_in = 1'b1;
    wait_to(106); sig_in = 1'b0;
    wait_to(110);
    chk("R7 overrun set", {15'd0, overrun}, 16'h0001);
    wait_to(300);
    chk("R7 overrun sticky", {15'd0, overrun}, 16'h0001);

    summary();
    $finish;
  end
endmodule